// File: doc/BRIEF.md
# Configuration Access Translator

This block sits inside a host bridge and turns processor accesses into configuration read and write requests for the PCI hierarchy. It offers two ways in. The first is an I/O port pair: a 32-bit address register that software fills with a target location and an enable flag, and a data window through which the actual configuration access is made. The second is a memory-mapped window, where the target bus, device, function and register are carried directly in the offset from the window base. This window reaches a 4 KiB register space per function.

Both ways in produce the same request on one configuration request interface. The request carries bus, device, function, register offset, byte enables and write data. A matching completion interface returns read data. Only one configuration request is in flight at a time. The processor access that started it stays stalled until its completion comes back. Accesses that decode to neither path complete at once, return all ones on a read, and start nothing.

Top module: `cfgx_top`

## Requirements
- R1: After reset the address register reads as zero, `cfg_req_valid` is low and `hst_done` is low.
- R2: An I/O write to byte addresses 0xCF8 to 0xCFB updates only the bytes of the address register picked by its byte enables and issues no request. An I/O read there returns the whole register.
- R3: When bit 31 of the address register is set, an I/O access to 0xCFC to 0xCFF issues one request. The request takes bus from register bits 23:16, device from 15:11, function from 10:8, and register offset from bits 7:2 with offset bits 1:0 forced to zero. Write data and the write flag are passed through unchanged.
- R4: When bit 31 of the address register is clear, a data-port access issues no request. A read returns 0xFFFFFFFF and a write is dropped.
- R5: Byte enables come from the access size (`hst_size` 0 = byte, 1 = word, 2 or 3 = dword) and address bits 1:0. A byte access sets bit `addr[1:0]`. A word access sets 0b0011 or 0b1100, chosen by `addr[1]`. A dword access sets 0b1111.
- R6: A memory access whose address bits 31:28 equal the window base issues a request. It takes bus from address bits 27:20, device from 19:15, function from 14:12, and register offset from 11:2 with bits 1:0 zero. For example, 0xF0300500 gives bus 3, device 0, function 0, offset 0x500.
- R7: An I/O access outside 0xCF8 to 0xCFF, or a memory access outside the window, issues no request. A read returns 0xFFFFFFFF.
- R8: Once `cfg_req_valid` rises, it and every request field stay stable until `cfg_req_ready` is sampled high.
- R9: At most one request is outstanding. A configuration access completes only after its completion arrives, returning the completion data on a read and zero on a write.
- R10: `hst_done` is a single-cycle pulse. For a configuration access it rises exactly one cycle after `cfg_cpl_valid` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_valid | input | 1 | Processor access present; held until `hst_done` |
| hst_io | input | 1 | 1 = I/O space, 0 = memory space |
| hst_write | input | 1 | 1 = write |
| hst_addr | input | 32 | Byte address of the access |
| hst_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| hst_wdata | input | 32 | Write data, already placed in its byte lanes |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Read data, valid with `hst_done` |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Request accepted |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 12 | Register byte offset, dword aligned |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_cpl_valid | input | 1 | Completion for the outstanding request |
| cfg_cpl_rdata | input | 32 | Completion read data |

## Verification
Two events can meet in the same cycle. One is an address-register write finishing. The other is the decode of the very next data-port access, which must already see the new register value. The bench starts each access right after the previous `hst_done`, so the two always sit back to back. It judges the request fields against its own model of the register. The second collision is a completion that arrives in the first cycle after the request is accepted, which the responder produces with zero-delay draws. There the bench checks that `hst_done` follows by exactly one cycle.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int unsigned CFGX_DW  = 32;
    localparam int unsigned CFGX_BEW = CFGX_DW / 8;
    localparam int unsigned BUS_W    = 8;
    localparam int unsigned DEV_W    = 5;
    localparam int unsigned FN_W     = 3;
    localparam int unsigned REG_W    = 12;

    typedef enum logic [1:0] {
        ACC_PTR_WR = 2'd0,
        ACC_PTR_RD = 2'd1,
        ACC_CFG    = 2'd2,
        ACC_VOID   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_RESP = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [BUS_W-1:0]    bus;
        logic [DEV_W-1:0]    dev;
        logic [FN_W-1:0]     fn;
        logic [REG_W-1:0]    regofs;
        logic [CFGX_BEW-1:0] be;
    } cfg_tgt_t;

    typedef struct packed {
        seq_st_e            st;
        logic               wr;
        cfg_tgt_t           tgt;
        logic [CFGX_DW-1:0] wdata;
        logic [CFGX_DW-1:0] rdata;
    } seq_t;

    function automatic logic [CFGX_BEW-1:0] lane_mask(input logic [1:0] size,
                                                      input logic [1:0] lo);
        logic [CFGX_BEW-1:0] m;
        case (size)
            2'd0:    m = CFGX_BEW'(1) << lo;
            2'd1:    m = lo[1] ? 4'b1100 : 4'b0011;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgx_ptr_reg.sv
module cfgx_ptr_reg
    import cfgx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CFGX_BEW-1:0] be,
    input  logic [CFGX_DW-1:0]  wdata,
    output logic [CFGX_DW-1:0]  value
);
    logic [CFGX_DW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        for (int i = 0; i < int'(CFGX_BEW); i++) begin
            if (we && be[i]) ptr_d[8*i +: 8] = wdata[8*i +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign value = ptr_q;
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 32,
    parameter int unsigned        IO_W     = 16,
    parameter logic [IO_W-1:0]    PTR_PORT = 16'h0CF8,
    parameter logic [IO_W-1:0]    DAT_PORT = 16'h0CFC,
    parameter logic [ADDR_W-1:0]  WIN_BASE = 32'hF000_0000,
    parameter int unsigned        WIN_LSB  = 28
) (
    input  logic               io,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         size,
    input  logic [CFGX_DW-1:0] ptr,
    output acc_kind_e          kind,
    output cfg_tgt_t           tgt
);
    localparam int unsigned PORT_HI = IO_W - 1;
    localparam int unsigned TAG_W   = ADDR_W - WIN_LSB;

    logic hit_ptr, hit_dat, hit_win, io_ok;
    logic [CFGX_BEW-1:0] be;

    always_comb begin
        io_ok   = (addr[ADDR_W-1:IO_W] == '0);
        hit_ptr = io && io_ok && (addr[PORT_HI:2] == PTR_PORT[PORT_HI:2]);
        hit_dat = io && io_ok && (addr[PORT_HI:2] == DAT_PORT[PORT_HI:2]);
        hit_win = !io && (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
        be      = lane_mask(size, addr[1:0]);

        tgt = '0;
        tgt.be = be;
        kind = ACC_VOID;
        if (hit_ptr) begin
            kind = ACC_PTR_WR;
        end else if (hit_dat) begin
            if (ptr[CFGX_DW-1]) begin
                kind       = ACC_CFG;
                tgt.bus    = ptr[23:16];
                tgt.dev    = ptr[15:11];
                tgt.fn     = ptr[10:8];
                tgt.regofs = {4'b0000, ptr[7:2], 2'b00};
            end
        end else if (hit_win) begin
            kind       = ACC_CFG;
            tgt.bus    = addr[27:20];
            tgt.dev    = addr[19:15];
            tgt.fn     = addr[14:12];
            tgt.regofs = {addr[11:2], 2'b00};
        end
    end

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = WIN_BASE[ADDR_W-1:WIN_LSB];
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
    import cfgx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_valid,
    input  logic               hst_write,
    input  logic [CFGX_DW-1:0] hst_wdata,
    input  acc_kind_e          kind,
    input  cfg_tgt_t           tgt,
    input  logic [CFGX_DW-1:0] ptr,
    output logic               ptr_we,
    output logic               hst_done,
    output logic [CFGX_DW-1:0] hst_rdata,
    output logic               cfg_req_valid,
    input  logic               cfg_req_ready,
    output logic               cfg_write,
    output cfg_tgt_t           cfg_tgt,
    output logic [CFGX_DW-1:0] cfg_wdata,
    input  logic               cfg_cpl_valid,
    input  logic [CFGX_DW-1:0] cfg_cpl_rdata
);
    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        ptr_we = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (hst_valid) begin
                    s_d.wr    = hst_write;
                    s_d.wdata = hst_wdata;
                    s_d.tgt   = tgt;
                    s_d.rdata = '0;
                    s_d.st    = SQ_RESP;
                    case (kind)
                        ACC_PTR_WR: begin
                            if (hst_write) ptr_we = 1'b1;
                            else           s_d.rdata = ptr;
                        end
                        ACC_CFG:    s_d.st = SQ_REQ;
                        default:    s_d.rdata = hst_write ? '0 : '1;
                    endcase
                end
            end
            SQ_REQ: begin
                if (cfg_req_ready) s_d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (cfg_cpl_valid) begin
                    s_d.rdata = s_q.wr ? '0 : cfg_cpl_rdata;
                    s_d.st    = SQ_RESP;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, wr: 1'b0, tgt: '0, wdata: '0, rdata: '0};
        else        s_q <= s_d;
    end

    assign hst_done      = (s_q.st == SQ_RESP);
    assign hst_rdata     = s_q.rdata;
    assign cfg_req_valid = (s_q.st == SQ_REQ);
    assign cfg_write     = s_q.wr;
    assign cfg_tgt       = s_q.tgt;
    assign cfg_wdata     = s_q.wdata;
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
    import cfgx_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter int unsigned       IO_W     = 16,
    parameter logic [IO_W-1:0]   PTR_PORT = 16'h0CF8,
    parameter logic [IO_W-1:0]   DAT_PORT = 16'h0CFC,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000,
    parameter int unsigned       WIN_LSB  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_valid,
    input  logic              hst_io,
    input  logic              hst_write,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [1:0]        hst_size,
    input  logic [31:0]       hst_wdata,
    output logic              hst_done,
    output logic [31:0]       hst_rdata,
    output logic              cfg_req_valid,
    input  logic              cfg_req_ready,
    output logic              cfg_write,
    output logic [7:0]        cfg_bus,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_fn,
    output logic [11:0]       cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_cpl_valid,
    input  logic [31:0]       cfg_cpl_rdata
);
    acc_kind_e          kind;
    cfg_tgt_t           tgt, out_tgt;
    logic [CFGX_DW-1:0] ptr;
    logic               ptr_we;

    cfgx_ptr_reg ptr_i (
        .clk(clk), .rst_n(rst_n), .we(ptr_we),
        .be(tgt.be), .wdata(hst_wdata), .value(ptr)
    );

    cfgx_decode #(
        .ADDR_W(ADDR_W), .IO_W(IO_W), .PTR_PORT(PTR_PORT),
        .DAT_PORT(DAT_PORT), .WIN_BASE(WIN_BASE), .WIN_LSB(WIN_LSB)
    ) dec_i (
        .io(hst_io), .addr(hst_addr), .size(hst_size), .ptr(ptr),
        .kind(kind), .tgt(tgt)
    );

    cfgx_seq seq_i (
        .clk(clk), .rst_n(rst_n),
        .hst_valid(hst_valid), .hst_write(hst_write), .hst_wdata(hst_wdata),
        .kind(kind), .tgt(tgt), .ptr(ptr), .ptr_we(ptr_we),
        .hst_done(hst_done), .hst_rdata(hst_rdata),
        .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
        .cfg_write(cfg_write), .cfg_tgt(out_tgt), .cfg_wdata(cfg_wdata),
        .cfg_cpl_valid(cfg_cpl_valid), .cfg_cpl_rdata(cfg_cpl_rdata)
    );

    assign cfg_bus = out_tgt.bus;
    assign cfg_dev = out_tgt.dev;
    assign cfg_fn  = out_tgt.fn;
    assign cfg_reg = out_tgt.regofs;
    assign cfg_be  = out_tgt.be;
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hst_done,
    input logic        cfg_req_valid,
    input logic        cfg_req_ready,
    input logic        cfg_write,
    input logic [7:0]  cfg_bus,
    input logic [4:0]  cfg_dev,
    input logic [2:0]  cfg_fn,
    input logic [11:0] cfg_reg,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic        cfg_cpl_valid
);
    logic in_flight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             in_flight <= 1'b0;
        else if (cfg_req_valid && cfg_req_ready) in_flight <= 1'b1;
        else if (cfg_cpl_valid)                  in_flight <= 1'b0;
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_bus) &&
        $stable(cfg_dev) && $stable(cfg_fn) && $stable(cfg_reg) &&
        $stable(cfg_be) && $stable(cfg_write) && $stable(cfg_wdata));

    assert_one_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight |-> !cfg_req_valid);

    assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight && cfg_cpl_valid |=> hst_done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |=> !hst_done);

    assert_no_done_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight && !cfg_cpl_valid |=> !hst_done);

    assert_dword_ofs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> cfg_reg[1:0] == 2'b00);

    assert_lane_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 ||
                           cfg_be == 4'b1100 || cfg_be == 4'b1111));
endmodule

bind cfgx_top cfgx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .hst_done(hst_done),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_cpl_valid(cfg_cpl_valid)
);

// File: tb/cfgx_top_tb_top.sv
module cfgx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_valid = 1'b0, hst_io = 1'b0, hst_write = 1'b0;
    logic [31:0] hst_addr = '0, hst_wdata = '0;
    logic [1:0]  hst_size = '0;
    logic        hst_done;
    logic [31:0] hst_rdata;
    logic        cfg_req_valid, cfg_write;
    logic        cfg_req_ready = 1'b0, cfg_cpl_valid = 1'b0;
    logic [31:0] cfg_cpl_rdata = '0, cfg_wdata;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [11:0] cfg_reg;
    logic [3:0]  cfg_be;

    always #10 clk = ~clk;

    cfgx_top dut_i (.*);

    int total = 0, bad = 0, cyc = 0;
    int nreq = 0, cpl_cyc = 0, done_cyc = 0;
    logic [7:0]  c_bus;
    logic [4:0]  c_dev;
    logic [2:0]  c_fn;
    logic [11:0] c_reg;
    logic [3:0]  c_be;
    logic [31:0] c_wd;
    logic        c_wr;
    logic [31:0] m_ptr = '0;
    logic [31:0] got;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] cpl_model(logic [7:0] b, logic [4:0] d,
                                              logic [2:0] f, logic [11:0] r);
        return {b, d, f, r, 4'hA};
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] size, logic [1:0] lo);
        if (size == 2'd0) return 4'b0001 << lo;
        if (size == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // completion responder with random delays
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_req_valid) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                c_bus = cfg_bus; c_dev = cfg_dev; c_fn = cfg_fn; c_reg = cfg_reg;
                c_be = cfg_be; c_wd = cfg_wdata; c_wr = cfg_write;
                nreq++;
                cfg_req_ready = 1'b1;
                @(negedge clk);
                cfg_req_ready = 1'b0;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                cfg_cpl_valid = 1'b1;
                cfg_cpl_rdata = cpl_model(c_bus, c_dev, c_fn, c_reg);
                cpl_cyc = cyc;
                @(negedge clk);
                cfg_cpl_valid = 1'b0;
            end
        end
    end

    task automatic acc(bit io, bit wr, logic [31:0] a, logic [1:0] sz, logic [31:0] wd);
        @(negedge clk);
        hst_valid = 1'b1; hst_io = io; hst_write = wr;
        hst_addr = a; hst_size = sz; hst_wdata = wd;
        do @(negedge clk); while (!hst_done);
        got = hst_rdata; done_cyc = cyc;
        hst_valid = 1'b0;
    endtask

    task automatic ptr_write(logic [1:0] sz, logic [1:0] lo, logic [31:0] wd);
        int n0 = nreq;
        logic [3:0] m = exp_be(sz, lo);
        acc(1, 1, 32'h0CF8 | lo, sz, wd);
        for (int i = 0; i < 4; i++) if (m[i]) m_ptr[8*i +: 8] = wd[8*i +: 8];
        chk(nreq == n0, "R2", "no request on pointer write", nreq - n0, 0);
    endtask

    task automatic ptr_read();
        acc(1, 0, 32'h0CF8, 2'd2, 32'h0);
        chk(got == m_ptr, "R2", "pointer readback", got, m_ptr);
    endtask

    task automatic cfg_check(string rq, bit wr, logic [31:0] wd, logic [7:0] b, logic [4:0] d,
                             logic [2:0] f, logic [11:0] r, logic [3:0] be, int n0);
        chk(nreq == n0 + 1, rq, "one request", nreq - n0, 1);
        chk({c_bus, c_dev, c_fn, c_reg} == {b, d, f, r}, rq, "bus/dev/fn/reg",
            {4'h0, c_bus, c_dev, c_fn, c_reg}, {4'h0, b, d, f, r});
        chk(c_be == be, "R5", "byte enables", c_be, be);
        chk(c_wr == wr, rq, "write flag", c_wr, wr);
        if (wr) begin
            chk(c_wd == wd, rq, "write data", c_wd, wd);
            chk(got == 0, "R9", "write completion data", got, 0);
        end else begin
            chk(got == cpl_model(b, d, f, r), "R9", "read data", got, cpl_model(b, d, f, r));
        end
        chk(done_cyc == cpl_cyc + 1, "R10", "done latency", done_cyc - cpl_cyc, 1);
    endtask

    task automatic port_acc(bit wr, logic [1:0] sz, logic [1:0] lo, logic [31:0] wd);
        int n0 = nreq;
        acc(1, wr, 32'h0CFC | lo, sz, wd);
        if (m_ptr[31]) begin
            cfg_check("R3", wr, wd, m_ptr[23:16], m_ptr[15:11], m_ptr[10:8],
                      {4'h0, m_ptr[7:2], 2'b00}, exp_be(sz, lo), n0);
        end else begin
            chk(nreq == n0, "R4", "disabled access makes no request", nreq - n0, 0);
            if (!wr) chk(got == 32'hFFFF_FFFF, "R4", "disabled read all ones", got, 32'hFFFF_FFFF);
        end
    endtask

    task automatic win_acc(bit wr, logic [27:0] ofs, logic [1:0] sz, logic [31:0] wd);
        int n0 = nreq;
        logic [31:0] a = {4'hF, ofs};
        acc(0, wr, a, sz, wd);
        cfg_check("R6", wr, wd, a[27:20], a[19:15], a[14:12], {a[11:2], 2'b00},
                  exp_be(sz, a[1:0]), n0);
    endtask

    task automatic stray(bit io, bit wr, logic [31:0] a);
        int n0 = nreq;
        acc(io, wr, a, 2'd2, 32'h1234_5678);
        chk(nreq == n0, "R7", "stray access makes no request", nreq - n0, 0);
        if (!wr) chk(got == 32'hFFFF_FFFF, "R7", "stray read all ones", got, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cfg_req_valid == 0, "R1", "req idle after reset", cfg_req_valid, 0);
        chk(hst_done == 0, "R1", "done low after reset", hst_done, 0);
        rst_n = 1'b1;
        ptr_read();
        chk(got == 0, "R1", "pointer zero after reset", got, 0);

        // directed: disabled data port
        port_acc(0, 2'd2, 2'd0, 0);
        port_acc(1, 2'd2, 2'd0, 32'hDEAD_BEEF);
        // documented example 0x80030004
        ptr_write(2'd2, 2'd0, 32'h8003_0004);
        ptr_read();
        port_acc(0, 2'd2, 2'd0, 0);
        port_acc(1, 2'd0, 2'd3, 32'hAB00_0000);
        port_acc(0, 2'd1, 2'd2, 0);
        // byte update of pointer, clearing enable bit via top byte
        ptr_write(2'd0, 2'd3, 32'h0000_0000);
        ptr_read();
        port_acc(0, 2'd2, 2'd0, 0);
        ptr_write(2'd1, 2'd2, 32'h80FF_0000);
        ptr_read();
        // window example
        win_acc(0, 28'h030_0500, 2'd2, 0);
        win_acc(1, 28'hFFF_FFFF, 2'd0, 32'h7700_0000);
        stray(1, 0, 32'h0000_0CF0);
        stray(0, 0, 32'hE030_0500);
        stray(1, 1, 32'h0001_0CFC);

        for (int k = 0; k < 250; k++) begin
            int sel = $urandom_range(0, 9);
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic [1:0] lo = 2'($urandom_range(0, 3));
            bit wr = 1'($urandom_range(0, 1));
            logic [31:0] wd = $urandom;
            if (sel < 2) ptr_write(sz, lo, wd);
            else if (sel < 3) ptr_read();
            else if (sel < 6) port_acc(wr, sz, lo, wd);
            else if (sel < 8) win_acc(wr, 28'($urandom), sz, wd);
            else if (sel < 9) stray(1, wr, 32'h0000_0D00 | 32'($urandom_range(0, 255)));
            else stray(0, wr, {4'($urandom_range(0, 14)), 28'($urandom)});
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule